// File: doc/BRIEF.md
# Banked Stack Pointer Register File

This block holds the general registers of a 32-bit processor: eight data registers D0 to D7, seven address registers A0 to A6, the stack pointer in use (A7) and a second, parked stack pointer (OTHER_A7). An execution unit reaches the file through a core port. Each cycle it can read two operands and write one result at word or longword size. An external debugger reaches the file through a command port, where an 8-bit command byte selects a register and a direction.

Neither physical stack-pointer register is fixed as supervisor or user. The block keeps the supervisor bit. When a write changes that bit, the contents of A7 and OTHER_A7 are exchanged in the same clock, so A7 always holds the stack pointer of the current mode. Debug commands reach A7 and OTHER_A7 as they are, and the mode is not taken into account. The debugger works out which one is which from the supervisor bit.

Top module: `bsp_regfile`

## Requirements
- R1: After reset, D0 holds CFG_D0 and D1 holds CFG_D1. Every other register, including both stack pointers, holds zero. The supervisor bit equals SUP_RESET (default 1).
- R2: Core read ports are combinational. Index 0-7 selects Dn, 8-14 selects A0-A6 and 15 selects the active A7. A read returns the value held before the write of the same cycle.
- R3: A core write with wr_long=1 replaces all 32 bits of the selected register on the next clock edge.
- R4: A core word write (wr_long=0) to a data register (index 0-7) replaces bits 15:0 only. Bits 31:16 keep their value.
- R5: A core word write to an address register or A7 (index 8-15) stores wr_data[15:0] sign-extended from bit 15 to 32 bits.
- R6: Debug write commands store all 32 bits of dbg_wdata. 0x60+n writes Dn (n=0-7). 0x68+n writes An (n=0-6). 0x6F writes the active A7. 0x70 writes OTHER_A7.
- R7: Debug read commands drive dbg_rdata combinationally. 0x40+n reads Dn. 0x48+n reads An. 0x4F reads the active A7. 0x50 reads OTHER_A7.
- R8: Any other command byte, or dbg_valid low, changes no register and drives dbg_rdata to zero.
- R9: When sup_we is high and sup_in differs from the current bit, the bit takes sup_in and A7 and OTHER_A7 exchange contents in that clock. When sup_in equals the current bit, nothing is exchanged.
- R10: A write to A7 or OTHER_A7 in the same cycle as a mode change lands first, and the exchange then applies to the written value.
- R11: When a debug write and a core write select the same register in one cycle, the debug value is stored. When they select different registers, both are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Core read port A register index |
| rd_a_data | output | 32 | Core read port A data |
| rd_b_idx | input | 4 | Core read port B register index |
| rd_b_data | output | 32 | Core read port B data |
| wr_en | input | 1 | Core write enable |
| wr_idx | input | 4 | Core write register index |
| wr_long | input | 1 | 1 = longword write, 0 = word write |
| wr_data | input | 32 | Core write data |
| sup_we | input | 1 | Supervisor bit write strobe |
| sup_in | input | 1 | New supervisor bit value |
| sup_out | output | 1 | Current supervisor bit |
| dbg_valid | input | 1 | Debug command present |
| dbg_cmd | input | 8 | Debug command byte |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, zero without a read command |

## Verification
Three pairs of functions can fall in the same cycle. A debug write can collide with a core write to the same register. A stack-pointer write, from either port, can coincide with a supervisor-bit change. A core read can hit a register that is being written. The bench forces each pair directly: matching wr_idx with the debug command's register, raising sup_we with a differing sup_in while 0x6F, 0x70 or a core write to index 15 is present, and pointing a read port at the write index. A behavioural model then judges the outcome by applying the core write, then the debug write, then the exchange. After that, a long random mix throws these collisions together freely, and every clock is compared.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    // Register file geometry
    localparam int NUM_D   = 8;               // data registers
    localparam int NUM_A   = 7;               // address registers below the stack pointer
    localparam int NREG    = NUM_D + NUM_A + 2; // plus active and parked stack pointer
    localparam int IDX_W   = $clog2(NREG);
    localparam int CIW     = 4;               // core index width (0..15)
    localparam int IDX_A7  = NUM_D + NUM_A;   // active stack pointer slot
    localparam int IDX_OTH = IDX_A7 + 1;      // parked stack pointer slot

    // Debug command groups, decoded on cmd[7:3]
    localparam logic [4:0] GRP_RD_D = 5'b01000;  // 0x40..0x47
    localparam logic [4:0] GRP_RD_A = 5'b01001;  // 0x48..0x4F
    localparam logic [4:0] GRP_RD_O = 5'b01010;  // 0x50
    localparam logic [4:0] GRP_WR_D = 5'b01100;  // 0x60..0x67
    localparam logic [4:0] GRP_WR_A = 5'b01101;  // 0x68..0x6F
    localparam logic [4:0] GRP_WR_O = 5'b01110;  // 0x70

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [IDX_W-1:0] idx;
    } dbg_op_t;

endpackage

// File: rtl/bsp_cmd_decode.sv
module bsp_cmd_decode
    import bsp_pkg::*;
(
    input  logic       valid,
    input  logic [7:0] cmd,
    output dbg_op_t    op
);

    logic [IDX_W-1:0] low_d;
    logic [IDX_W-1:0] low_a;

    assign low_d = IDX_W'(cmd[2:0]);
    assign low_a = IDX_W'(NUM_D) + IDX_W'(cmd[2:0]);

    always_comb begin
        op = '0;
        if (valid) begin
            unique case (cmd[7:3])
                GRP_RD_D: begin op.rd = 1'b1; op.idx = low_d; end
                GRP_RD_A: begin op.rd = 1'b1; op.idx = low_a; end
                GRP_WR_D: begin op.wr = 1'b1; op.idx = low_d; end
                GRP_WR_A: begin op.wr = 1'b1; op.idx = low_a; end
                GRP_RD_O: begin
                    if (cmd[2:0] == 3'd0) begin
                        op.rd  = 1'b1;
                        op.idx = IDX_W'(IDX_OTH);
                    end
                end
                GRP_WR_O: begin
                    if (cmd[2:0] == 3'd0) begin
                        op.wr  = 1'b1;
                        op.idx = IDX_W'(IDX_OTH);
                    end
                end
                default: op = '0;
            endcase
        end
    end

endmodule

// File: rtl/bsp_wfmt.sv
module bsp_wfmt #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] new_val,
    input  logic          is_long,
    input  logic          is_addr,
    output logic [DW-1:0] merged
);

    localparam int HW = DW / 2;

    always_comb begin
        if (is_long)
            merged = new_val;
        else if (is_addr)
            merged = {{HW{new_val[HW-1]}}, new_val[HW-1:0]};
        else
            merged = {old_val[DW-1:HW], new_val[HW-1:0]};
    end

endmodule

// File: rtl/bsp_rdmux.sv
module bsp_rdmux #(
    parameter int DW   = 32,
    parameter int NREG = 17,
    parameter int IW   = 5
) (
    input  logic [NREG-1:0][DW-1:0] regs,
    input  logic                    en,
    input  logic [IW-1:0]           idx,
    output logic [DW-1:0]           data
);

    always_comb begin
        if (en && (idx < IW'(NREG)))
            data = regs[idx];
        else
            data = '0;
    end

endmodule

// File: rtl/bsp_regfile.sv
module bsp_regfile
    import bsp_pkg::*;
#(
    parameter int            DW        = 32,
    parameter logic [DW-1:0] CFG_D0    = 32'h1100_2A5C,
    parameter logic [DW-1:0] CFG_D1    = 32'h0040_8010,
    parameter logic          SUP_RESET = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    rd_a_idx,
    output logic [DW-1:0] rd_a_data,
    input  logic [3:0]    rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [3:0]    wr_idx,
    input  logic          wr_long,
    input  logic [DW-1:0] wr_data,
    input  logic          sup_we,
    input  logic          sup_in,
    output logic          sup_out,
    input  logic          dbg_valid,
    input  logic [7:0]    dbg_cmd,
    input  logic [DW-1:0] dbg_wdata,
    output logic [DW-1:0] dbg_rdata
);

    localparam int NRP = 2;       // core read ports
    localparam int HW  = DW / 2;

    typedef struct packed {
        logic                    sup;
        logic [NREG-1:0][DW-1:0] regs;
    } st_t;

    st_t q, d;

    dbg_op_t          dop;
    logic [IDX_W-1:0] wr_ext;
    logic [DW-1:0]    core_val;
    logic             mode_flip;
    logic             sp_touch;
    logic [DW-1:0]    tmp_sp;

    // Debug command decode
    bsp_cmd_decode u_dec (
        .valid (dbg_valid),
        .cmd   (dbg_cmd),
        .op    (dop)
    );

    assign wr_ext = IDX_W'(wr_idx);

    // Core write data shaping by size and register class
    bsp_wfmt #(.DW(DW)) u_fmt (
        .old_val (q.regs[wr_ext]),
        .new_val (wr_data),
        .is_long (wr_long),
        .is_addr (wr_idx >= 4'(NUM_D)),
        .merged  (core_val)
    );

    // Core read ports
    logic [NRP-1:0][CIW-1:0] c_idx;
    logic [NRP-1:0][DW-1:0]  c_dat;

    assign c_idx[0]  = rd_a_idx;
    assign c_idx[1]  = rd_b_idx;
    assign rd_a_data = c_dat[0];
    assign rd_b_data = c_dat[1];

    for (genvar p = 0; p < NRP; p++) begin : g_rd
        bsp_rdmux #(.DW(DW), .NREG(NREG), .IW(IDX_W)) u_rd (
            .regs (q.regs),
            .en   (1'b1),
            .idx  (IDX_W'(c_idx[p])),
            .data (c_dat[p])
        );
    end

    // Debug read port
    bsp_rdmux #(.DW(DW), .NREG(NREG), .IW(IDX_W)) u_dbg_rd (
        .regs (q.regs),
        .en   (dop.rd),
        .idx  (dop.idx),
        .data (dbg_rdata)
    );

    assign sup_out   = q.sup;
    assign mode_flip = sup_we && (sup_in != q.sup);
    assign sp_touch  = (wr_en && (wr_ext == IDX_W'(IDX_A7)))
                     || (dop.wr && (dop.idx >= IDX_W'(IDX_A7)));

    // Next state: core write, then debug write (wins), then stack exchange
    always_comb begin
        d      = q;
        tmp_sp = '0;
        if (wr_en)
            d.regs[wr_ext] = core_val;
        if (dop.wr)
            d.regs[dop.idx] = dbg_wdata;
        if (mode_flip) begin
            tmp_sp           = d.regs[IDX_A7];
            d.regs[IDX_A7]   = d.regs[IDX_OTH];
            d.regs[IDX_OTH]  = tmp_sp;
            d.sup            = sup_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.regs    <= '0;
            q.regs[0] <= CFG_D0;
            q.regs[1] <= CFG_D1;
            q.sup     <= SUP_RESET;
        end else begin
            q <= d;
        end
    end

    // R9: a mode change with no stack-pointer write exchanges the two pointers
    a_r9_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flip && !sp_touch) |=>
            (q.regs[IDX_A7] == $past(q.regs[IDX_OTH])) &&
            (q.regs[IDX_OTH] == $past(q.regs[IDX_A7])) &&
            (q.sup != $past(q.sup)));

    // R9: rewriting the current mode value leaves both pointers alone
    a_r9_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_we && (sup_in == q.sup) && !sp_touch) |=>
            $stable(q.regs[IDX_A7]) && $stable(q.regs[IDX_OTH]) && $stable(q.sup));

    // R11: debug write beats a core write to the same register
    a_r11_dbg_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dop.wr && (dop.idx == wr_ext) && !mode_flip) |=>
            (q.regs[$past(dop.idx)] == $past(dbg_wdata)));

    // R5: word write to an address register is sign-extended
    a_r5_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_long && (wr_idx >= 4'(NUM_D)) && !dop.wr && !mode_flip) |=>
            (q.regs[$past(wr_ext)][DW-1:HW] == {HW{$past(wr_data[HW-1])}}));

    // R4: word write to a data register keeps the upper half
    a_r4_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_long && (wr_idx < 4'(NUM_D)) && !dop.wr) |=>
            (q.regs[$past(wr_ext)][DW-1:HW] == $past(q.regs[wr_ext][DW-1:HW])));

    // R8: no read command means a zero debug read bus
    a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_valid |-> (dbg_rdata == '0));

endmodule

// File: tb/test_bsp_regfile.sv
`timescale 1ns/1ps
module test_bsp_regfile;

    localparam logic [31:0] C0 = 32'h1100_2A5C;
    localparam logic [31:0] C1 = 32'h0040_8010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, dbg_wdata = '0, dbg_rdata;
    logic        wr_en = 1'b0, wr_long = 1'b0, sup_we = 1'b0, sup_in = 1'b0;
    logic        sup_out, dbg_valid = 1'b0;
    logic [7:0]  dbg_cmd = '0;

    always #2.5 clk = ~clk;

    bsp_regfile i_bsp_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_long(wr_long), .wr_data(wr_data),
        .sup_we(sup_we), .sup_in(sup_in), .sup_out(sup_out),
        .dbg_valid(dbg_valid), .dbg_cmd(dbg_cmd),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    // Behavioural reference: 0-7 data, 8-14 address, 15 active SP, 16 parked SP
    logic [31:0] m_reg [17];
    logic        m_sup;
    int          errors = 0;
    int          checks = 0;
    string       cur_req = "R1";
    bit          done = 1'b0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic int dbg_target(input logic [7:0] c, output bit is_wr);
        is_wr = 1'b0;
        if (!dbg_valid) return -1;
        if (c >= 8'h40 && c <= 8'h4F) return int'(c) - 'h40;
        if (c == 8'h50) return 16;
        is_wr = 1'b1;
        if (c >= 8'h60 && c <= 8'h6F) return int'(c) - 'h60;
        if (c == 8'h70) return 16;
        is_wr = 1'b0;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 17; i++) m_reg[i] = 32'h0;
        m_reg[0] = C0;
        m_reg[1] = C1;
        m_sup = 1'b1;
    endtask

    // Compare outputs, clock once, advance the model
    task automatic tick();
        bit          w;
        int          t;
        logic [31:0] exp_dbg;
        logic [31:0] nx [17];
        logic [31:0] sw;
        #1;
        t = dbg_target(dbg_cmd, w);
        exp_dbg = (t >= 0 && !w) ? m_reg[t] : 32'h0;
        chk("rd_a", rd_a_data, m_reg[rd_a_idx]);
        chk("rd_b", rd_b_data, m_reg[rd_b_idx]);
        chk("dbg_rdata", dbg_rdata, exp_dbg);
        chk("sup_out", {31'h0, sup_out}, {31'h0, m_sup});
        @(posedge clk);
        for (int i = 0; i < 17; i++) nx[i] = m_reg[i];
        if (rst_n) begin
            if (wr_en) begin
                if (wr_long) nx[wr_idx] = wr_data;
                else if (wr_idx >= 8) nx[wr_idx] = {{16{wr_data[15]}}, wr_data[15:0]};
                else nx[wr_idx] = {m_reg[wr_idx][31:16], wr_data[15:0]};
            end
            if (t >= 0 && w) nx[t] = dbg_wdata;
            if (sup_we && sup_in != m_sup) begin
                sw = nx[15]; nx[15] = nx[16]; nx[16] = sw;
                m_sup = sup_in;
            end
            for (int i = 0; i < 17; i++) m_reg[i] = nx[i];
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; wr_long = 0; sup_we = 0; dbg_valid = 0; dbg_cmd = 8'h00;
    endtask

    task automatic dbg(input logic [7:0] c, input logic [31:0] v);
        dbg_valid = 1; dbg_cmd = c; dbg_wdata = v;
    endtask

    // Read every register through both ports
    task automatic dump();
        idle();
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
            dbg(8'h40 + 8'(i), 32'h0);
            tick();
        end
        dbg(8'h50, 32'h0); tick();
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        model_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents
        cur_req = "R1";
        dump();

        // R3: longword writes to every core index
        cur_req = "R3";
        for (int i = 0; i < 16; i++) begin
            wr_en = 1; wr_long = 1; wr_idx = 4'(i); wr_data = 32'hA500_0000 + 32'(i * 32'h1111);
            tick();
        end
        idle();
        dump();

        // R2: read of the register being written shows the old value
        cur_req = "R2";
        wr_en = 1; wr_long = 1; wr_idx = 4'd3; wr_data = 32'hDEAD_BEEF;
        rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        tick();
        idle(); tick();

        // R4: word write to data registers keeps upper half
        cur_req = "R4";
        wr_en = 1; wr_long = 0; wr_idx = 4'd5; wr_data = 32'h1234_8001; rd_a_idx = 4'd5; tick();
        wr_idx = 4'd0; wr_data = 32'hFFFF_7FFF; rd_a_idx = 4'd0; tick();
        idle(); tick();

        // R5: word write to address registers sign-extends
        cur_req = "R5";
        wr_en = 1; wr_long = 0; wr_idx = 4'd9; wr_data = 32'h0000_8123; rd_a_idx = 4'd9; tick();
        wr_idx = 4'd14; wr_data = 32'hFFFF_7123; rd_a_idx = 4'd14; tick();
        wr_idx = 4'd15; wr_data = 32'h0000_F000; rd_a_idx = 4'd15; tick();
        idle(); tick();

        // R6: debug writes, including both stack pointers
        cur_req = "R6";
        for (int n = 0; n < 8; n++) begin dbg(8'h60 + 8'(n), 32'h6000_0000 | 32'(n)); tick(); end
        for (int n = 0; n < 8; n++) begin dbg(8'h68 + 8'(n), 32'h6800_0000 | 32'(n)); tick(); end
        dbg(8'h70, 32'h7000_00AA); tick();
        idle();

        // R7: debug reads of all registers
        cur_req = "R7";
        dump();

        // R8: unused command bytes and invalid strobe change nothing
        cur_req = "R8";
        dbg(8'h58, 32'hBAD0_0001); tick();
        dbg(8'h71, 32'hBAD0_0002); tick();
        dbg(8'h51, 32'hBAD0_0003); tick();
        dbg(8'h00, 32'hBAD0_0004); tick();
        dbg(8'hE0, 32'hBAD0_0005); tick();
        dbg_valid = 0; dbg_cmd = 8'h60; dbg_wdata = 32'hBAD0_0006; tick();
        dump();

        // R9: mode change exchanges pointers; same value does not
        cur_req = "R9";
        sup_we = 1; sup_in = 0; tick();
        sup_we = 1; sup_in = 0; tick();
        idle(); dump();
        cur_req = "R9";
        sup_we = 1; sup_in = 1; tick();
        idle(); dump();

        // R10: stack-pointer writes coinciding with a mode change
        cur_req = "R10";
        dbg(8'h6F, 32'h0A7A_0001); sup_we = 1; sup_in = 0; tick();
        idle(); dump();
        cur_req = "R10";
        dbg(8'h70, 32'h0A7A_0002); sup_we = 1; sup_in = 1; tick();
        idle(); dump();
        cur_req = "R10";
        wr_en = 1; wr_long = 1; wr_idx = 4'd15; wr_data = 32'h0A7A_0003; sup_we = 1; sup_in = 0; tick();
        idle(); dump();

        // R11: same-register collision and independent writes
        cur_req = "R11";
        wr_en = 1; wr_long = 1; wr_idx = 4'd2; wr_data = 32'h0C0C_0C0C;
        dbg(8'h62, 32'h0D0D_0D0D); rd_a_idx = 4'd2; tick();
        wr_idx = 4'd10; wr_long = 0; wr_data = 32'h0000_9999;
        dbg(8'h6A, 32'h0D0D_1111); tick();
        wr_idx = 4'd4; wr_long = 1; wr_data = 32'h4444_4444;
        dbg(8'h6B, 32'h3333_3333); tick();
        idle(); dump();

        // Random mix of every function, compared every clock
        cur_req = "R11";
        for (int k = 0; k < 3000; k++) begin
            int sel;
            wr_en    = 1'($urandom_range(0, 1));
            wr_long  = 1'($urandom_range(0, 1));
            wr_idx   = 4'($urandom_range(0, 15));
            wr_data  = $urandom();
            sup_we   = ($urandom_range(0, 3) == 0);
            sup_in   = 1'($urandom_range(0, 1));
            rd_a_idx = 4'($urandom_range(0, 15));
            rd_b_idx = 4'($urandom_range(0, 15));
            dbg_valid = 1'($urandom_range(0, 1));
            sel = $urandom_range(0, 5);
            case (sel)
                0: dbg_cmd = 8'h40 + 8'($urandom_range(0, 15));
                1: dbg_cmd = 8'h60 + 8'($urandom_range(0, 15));
                2: dbg_cmd = 8'h50;
                3: dbg_cmd = 8'h70;
                4: dbg_cmd = 8'h60 + 8'(wr_idx);
                default: dbg_cmd = 8'($urandom());
            endcase
            dbg_wdata = $urandom();
            tick();
        end
        idle();
        dump();

        finish_run();
    end

endmodule